// File: doc/BRIEF.md
# Overflow-Freezing Performance Event Counter

This block is a single performance monitoring channel. A small control register picks one of eleven event lines by a 9-bit event code, enables counting and enables an overflow interrupt. A 48-bit counter then adds one on every clock in which the chosen line is high. Software may load the counter with any value at any time. Loading it with 2^48 − N makes it wrap on the Nth counted event.

When the counter carries out of bit 47, a sticky overflow flag is set. If the interrupt enable is set, a one-cycle interrupt pulse is also raised. That pulse arms a global freeze controller. After a fixed delay of `FRZ_DELAY` cycles (2 to 4), the controller stops all counting. The counter keeps counting through the wrap during that delay, so the value held at freeze equals the preload plus every event counted up to the cycle the freeze took hold. The count is readable on `cnt_o` at all times, and reading it does not disturb counting. A clear input lifts the freeze, and counting resumes from the held value.

Top module: `ovf_freeze_pmon`

## Requirements
- R1: After reset the count is 0, and the sticky flag, the interrupt pulse and the freeze output are all low. The control register resets to code 0x000 with counting and interrupt disabled.
- R2: While counting is enabled and the block is not frozen, the count rises by exactly one after each clock edge at which the selected event line is high. Unselected lines and a disabled counter leave the count unchanged. The code to line mapping is: 0x000→evt_i[0], 0x001→[1], 0x002→[2], 0x003→[3], 0x004→[4], 0x050→[5], 0x051→[6], 0x0F8→[7], 0x0F9→[8], 0x1DF→[9], 0x1E4→[10].
- R3: A control code outside the mapping of R2 selects a constant zero, so the count does not change whatever the event lines do.
- R4: An increment from all ones wraps the count to 0. In the following cycle `irq_o` is high for exactly one cycle, but only if the interrupt enable was set. With the interrupt enable clear, no pulse is raised and no freeze follows.
- R5: An overflow sets `ovf_sticky_o` whether or not the interrupt is enabled. The flag stays high until a cycle with `ovf_clr_i`. An overflow in that same cycle wins over the clear.
- R6: `frozen_o` rises exactly `FRZ_DELAY` cycles after the cycle in which `irq_o` is high. Events counted before it rises, including those after the wrap, are added to the count.
- R7: While `frozen_o` is high and no counter write occurs, the count holds its value.
- R8: A counter write takes effect at the next edge and wins over an increment in the same cycle. A write never sets the sticky flag or raises `irq_o`, even when the written value is all ones.
- R9: `frz_clr_i` drops `frozen_o` at the next edge. Counting then resumes from the held value, starting with the following edge.
- R10: The control register loads the code, the count enable and the interrupt enable on a cycle with `ctl_wr_i`, and holds them otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_i | input | 11 | Event lines, at most one count per line per cycle |
| ctl_wr_i | input | 1 | Load the control register |
| ctl_code_i | input | 9 | Event code to load |
| ctl_cnt_en_i | input | 1 | Count enable to load |
| ctl_irq_en_i | input | 1 | Overflow interrupt/freeze enable to load |
| cnt_wr_i | input | 1 | Write the counter |
| cnt_wdata_i | input | CNT_W (48) | Counter write value |
| ovf_clr_i | input | 1 | Clear the sticky overflow flag |
| frz_clr_i | input | 1 | Lift the global freeze |
| cnt_o | output | CNT_W (48) | Current count |
| ovf_sticky_o | output | 1 | Sticky overflow flag |
| irq_o | output | 1 | One-cycle overflow interrupt pulse |
| frozen_o | output | 1 | Global freeze active |

## Verification
The assertions assume that inputs change only between clock edges. They also assume that no second interrupt pulse and no freeze clear arrive while a freeze is still pending, because the delay check looks exactly `FRZ_DELAY` cycles back to the pulse. The bench drives every input at the falling edge. It issues `frz_clr_i` only after a freeze has fully taken hold. It starts each freeze run from a freshly loaded preload, so that only one overflow can happen inside the delay window.

// File: rtl/pfc_pkg.sv
package pfc_pkg;

    localparam int CODE_W  = 9;
    localparam int NUM_EVT = 11;

    typedef logic [CODE_W-1:0] code_t;

    // Event code assigned to each event line, by line index.
    localparam code_t EVT_CODE [NUM_EVT] = '{
        9'h000, 9'h001, 9'h002, 9'h003, 9'h004,
        9'h050, 9'h051, 9'h0F8, 9'h0F9, 9'h1DF, 9'h1E4
    };

    typedef struct packed {
        code_t code;
        logic  cnt_en;
        logic  irq_en;
    } ctl_t;

    function automatic logic code_known(input code_t c);
        logic hit;
        hit = 1'b0;
        for (int i = 0; i < NUM_EVT; i++) begin
            if (c == EVT_CODE[i]) hit = 1'b1;
        end
        return hit;
    endfunction

endpackage

// File: rtl/pfc_evt_select.sv
module pfc_evt_select
    import pfc_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ctl_wr_i,
    input  code_t              ctl_code_i,
    input  logic               ctl_cnt_en_i,
    input  logic               ctl_irq_en_i,
    input  logic [NUM_EVT-1:0] evt_i,
    output logic               sel_evt_o,
    output logic               cnt_en_o,
    output logic               irq_en_o
);

    ctl_t ctl_d, ctl_q;
    logic [NUM_EVT-1:0] hit;

    always_comb begin
        ctl_d = ctl_q;
        if (ctl_wr_i) begin
            ctl_d.code   = ctl_code_i;
            ctl_d.cnt_en = ctl_cnt_en_i;
            ctl_d.irq_en = ctl_irq_en_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    // One comparator per event line; an unmatched code leaves every hit low.
    for (genvar i = 0; i < NUM_EVT; i++) begin : g_match
        assign hit[i] = (ctl_q.code == EVT_CODE[i]) & evt_i[i];
    end

    assign sel_evt_o = |hit;
    assign cnt_en_o  = ctl_q.cnt_en;
    assign irq_en_o  = ctl_q.irq_en;

    assert_unassigned_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !code_known(ctl_q.code) |-> !sel_evt_o);

    assert_ctl_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr_i |=> (ctl_q.code == $past(ctl_code_i)) && (cnt_en_o == $past(ctl_cnt_en_i)));

    assert_ctl_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_wr_i |=> $stable(ctl_q));

endmodule

// File: rtl/pfc_counter.sv
module pfc_counter #(
    parameter int CNT_W = 48
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_i,
    input  logic             wr_i,
    input  logic [CNT_W-1:0] wdata_i,
    input  logic             irq_en_i,
    input  logic             ovf_clr_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             sticky_o,
    output logic             irq_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             stk;
        logic             irq;
    } cnt_st_t;

    cnt_st_t st_d, st_q;
    logic [CNT_W:0] sum;
    logic           carry;

    always_comb begin
        st_d  = st_q;
        sum   = {1'b0, st_q.cnt} + {{CNT_W{1'b0}}, 1'b1};
        carry = 1'b0;
        if (wr_i) begin
            st_d.cnt = wdata_i;
        end else if (inc_i) begin
            st_d.cnt = sum[CNT_W-1:0];
            carry    = sum[CNT_W];
        end
        st_d.irq = carry & irq_en_i;
        if (ovf_clr_i) st_d.stk = 1'b0;
        if (carry)     st_d.stk = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_o    = st_q.cnt;
    assign sticky_o = st_q.stk;
    assign irq_o    = st_q.irq;

    assert_write_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> cnt_o == $past(wdata_i));

    assert_write_no_ovf_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !sticky_o) |=> (!sticky_o && !irq_o));

    assert_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_i && !wr_i && (&cnt_o)) |=> (cnt_o == '0) && sticky_o);

    assert_irq_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o);

    assert_sticky_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sticky_o && !ovf_clr_i) |=> sticky_o);

    assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc_i && !wr_i) |=> $stable(cnt_o));

endmodule

// File: rtl/pfc_freeze_ctrl.sv
module pfc_freeze_ctrl #(
    parameter int FRZ_DELAY = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic irq_i,
    input  logic clr_i,
    output logic frozen_o
);

    localparam int DLY_W = $clog2(FRZ_DELAY + 1);

    typedef struct packed {
        logic             armed;
        logic [DLY_W-1:0] dly;
        logic             frozen;
    } frz_st_t;

    frz_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.armed) begin
            if (st_q.dly == DLY_W'(1)) begin
                st_d.armed  = 1'b0;
                st_d.frozen = 1'b1;
            end else begin
                st_d.dly = st_q.dly - DLY_W'(1);
            end
        end
        if (irq_i) begin
            st_d.armed = 1'b1;
            st_d.dly   = DLY_W'(FRZ_DELAY - 1);
        end
        if (clr_i) st_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign frozen_o = st_q.frozen;

    assert_freeze_delay_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frozen_o) |-> $past(irq_i, FRZ_DELAY));

    assert_freeze_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (frozen_o && !clr_i) |=> frozen_o);

    assert_freeze_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> !frozen_o);

endmodule

// File: rtl/ovf_freeze_pmon.sv
module ovf_freeze_pmon
    import pfc_pkg::*;
#(
    parameter int CNT_W     = 48,
    parameter int FRZ_DELAY = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_EVT-1:0] evt_i,
    input  logic               ctl_wr_i,
    input  logic [CODE_W-1:0]  ctl_code_i,
    input  logic               ctl_cnt_en_i,
    input  logic               ctl_irq_en_i,
    input  logic               cnt_wr_i,
    input  logic [CNT_W-1:0]   cnt_wdata_i,
    input  logic               ovf_clr_i,
    input  logic               frz_clr_i,
    output logic [CNT_W-1:0]   cnt_o,
    output logic               ovf_sticky_o,
    output logic               irq_o,
    output logic               frozen_o
);

    logic sel_evt;
    logic cnt_en;
    logic irq_en;
    logic inc;

    pfc_evt_select u_sel (
        .clk          (clk),
        .rst_n        (rst_n),
        .ctl_wr_i     (ctl_wr_i),
        .ctl_code_i   (ctl_code_i),
        .ctl_cnt_en_i (ctl_cnt_en_i),
        .ctl_irq_en_i (ctl_irq_en_i),
        .evt_i        (evt_i),
        .sel_evt_o    (sel_evt),
        .cnt_en_o     (cnt_en),
        .irq_en_o     (irq_en)
    );

    // Counting is gated by the global freeze.
    assign inc = sel_evt & cnt_en & ~frozen_o;

    pfc_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .inc_i     (inc),
        .wr_i      (cnt_wr_i),
        .wdata_i   (cnt_wdata_i),
        .irq_en_i  (irq_en),
        .ovf_clr_i (ovf_clr_i),
        .cnt_o     (cnt_o),
        .sticky_o  (ovf_sticky_o),
        .irq_o     (irq_o)
    );

    pfc_freeze_ctrl #(.FRZ_DELAY(FRZ_DELAY)) u_frz (
        .clk      (clk),
        .rst_n    (rst_n),
        .irq_i    (irq_o),
        .clr_i    (frz_clr_i),
        .frozen_o (frozen_o)
    );

    assert_frozen_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (frozen_o && !cnt_wr_i) |=> $stable(cnt_o));

    assert_masked_no_irq_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_en && !ctl_wr_i) |=> !irq_o);

    assert_disabled_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_en && !cnt_wr_i) |=> $stable(cnt_o));

endmodule

// File: tb/ovf_freeze_pmon_test.sv
`timescale 1ns/1ps
module ovf_freeze_pmon_test;

    localparam int CW = 48;
    localparam int D  = 3;
    localparam int NE = 11;
    localparam logic [CW-1:0] ALL1 = '1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NE-1:0] evt = '0;
    logic          ctl_wr = 1'b0;
    logic [8:0]    ctl_code = '0;
    logic          ctl_cnt_en = 1'b0;
    logic          ctl_irq_en = 1'b0;
    logic          cnt_wr = 1'b0;
    logic [CW-1:0] cnt_wdata = '0;
    logic          ovf_clr = 1'b0;
    logic          frz_clr = 1'b0;
    logic [CW-1:0] cnt;
    logic          sticky, irq, frozen;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [8:0] codes [NE] = '{9'h000, 9'h001, 9'h002, 9'h003, 9'h004,
                               9'h050, 9'h051, 9'h0F8, 9'h0F9, 9'h1DF, 9'h1E4};

    always #2 clk = ~clk;

    ovf_freeze_pmon #(.CNT_W(CW), .FRZ_DELAY(D)) uut (
        .clk (clk), .rst_n (rst_n), .evt_i (evt),
        .ctl_wr_i (ctl_wr), .ctl_code_i (ctl_code),
        .ctl_cnt_en_i (ctl_cnt_en), .ctl_irq_en_i (ctl_irq_en),
        .cnt_wr_i (cnt_wr), .cnt_wdata_i (cnt_wdata),
        .ovf_clr_i (ovf_clr), .frz_clr_i (frz_clr),
        .cnt_o (cnt), .ovf_sticky_o (sticky), .irq_o (irq), .frozen_o (frozen)
    );

    task automatic chk(input string req, input string what,
                       input logic [CW-1:0] act, input logic [CW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic cyc(input logic [NE-1:0] e);
        evt = e;
        @(negedge clk);
    endtask

    task automatic cfg(input logic [8:0] c, input logic en, input logic ie);
        ctl_wr = 1'b1; ctl_code = c; ctl_cnt_en = en; ctl_irq_en = ie;
        @(negedge clk);
        ctl_wr = 1'b0;
    endtask

    task automatic load(input logic [CW-1:0] v, input logic [NE-1:0] e);
        cnt_wr = 1'b1; cnt_wdata = v; evt = e;
        @(negedge clk);
        cnt_wr = 1'b0; evt = '0;
    endtask

    task automatic t_reset;
        chk("R1", "count", cnt, '0);
        chk("R1", "sticky", CW'(sticky), '0);
        chk("R1", "irq", CW'(irq), '0);
        chk("R1", "frozen", CW'(frozen), '0);
        cyc('1);   // counting disabled after reset
        chk("R1", "count after idle edge", cnt, '0);
    endtask

    task automatic t_basic;
        logic [6:0] pat = 7'b1001011;
        cfg(9'h050, 1'b1, 1'b0);
        load(48'd10, '0);
        for (int k = 0; k < 7; k++) cyc(~(NE'(1) << 5) | (NE'(pat[k]) << 5));
        evt = '0;
        chk("R2", "pattern on line 5", cnt, 48'd14);
    endtask

    task automatic t_codes;
        for (int i = 0; i < NE; i++) begin
            cfg(codes[i], 1'b1, 1'b0);
            load('0, '0);
            cyc(~(NE'(1) << i));
            cyc(~(NE'(1) << i));
            chk("R2", $sformatf("other lines, code %0h", codes[i]), cnt, '0);
            cyc(NE'(1) << i);
            cyc(NE'(1) << i);
            cyc(NE'(1) << i);
            evt = '0;
            chk("R2", $sformatf("own line, code %0h", codes[i]), cnt, 48'd3);
        end
    endtask

    task automatic t_unassigned;
        logic [8:0] bad [3] = '{9'h005, 9'h0FA, 9'h1FF};
        for (int i = 0; i < 3; i++) begin
            cfg(bad[i], 1'b1, 1'b0);
            load(48'd77, '0);
            for (int k = 0; k < 4; k++) cyc('1);
            evt = '0;
            chk("R3", $sformatf("unassigned code %0h", bad[i]), cnt, 48'd77);
        end
    endtask

    task automatic t_disabled;
        cfg(9'h001, 1'b0, 1'b0);
        load(48'd5, '0);
        for (int k = 0; k < 3; k++) cyc('1);
        evt = '0;
        chk("R2", "count enable off", cnt, 48'd5);
        chk("R10", "control held without write", CW'(uut.cnt_o == 48'd5), 48'd1);
    endtask

    task automatic t_write_masked_ovf;
        cfg(9'h0F9, 1'b1, 1'b0);
        load(48'd123, NE'(1) << 8);
        chk("R8", "write beats increment", cnt, 48'd123);
        load(ALL1, NE'(1) << 8);
        chk("R8", "write all ones", cnt, ALL1);
        chk("R8", "no sticky from write", CW'(sticky), '0);
        chk("R8", "no irq from write", CW'(irq), '0);
        cyc(NE'(1) << 8);
        chk("R4", "wrap to zero", cnt, '0);
        chk("R4", "masked irq stays low", CW'(irq), '0);
        chk("R5", "sticky set, irq masked", CW'(sticky), 48'd1);
        cyc(NE'(1) << 8);
        cyc(NE'(1) << 8);
        evt = '0;
        chk("R4", "counts on after masked wrap", cnt, 48'd2);
        chk("R4", "no freeze when masked", CW'(frozen), '0);
        cyc('0);
        chk("R5", "sticky holds", CW'(sticky), 48'd1);
        ovf_clr = 1'b1;
        cyc('0);
        ovf_clr = 1'b0;
        chk("R5", "sticky cleared", CW'(sticky), '0);
    endtask

    task automatic t_freeze;
        logic [CW-1:0] pre = ALL1 - 48'd4;   // overflow on the 5th event
        logic [CW-1:0] exp;
        cfg(9'h1E4, 1'b1, 1'b1);
        load(pre, '0);
        for (int k = 1; k <= 12; k++) begin
            cyc(NE'(1) << 10);
            exp = (k <= 5 + D) ? pre + CW'(k) : CW'(D);
            chk("R6", $sformatf("count at edge %0d", k), cnt, exp);
            chk("R4", $sformatf("irq at edge %0d", k), CW'(irq), CW'(k == 5));
            chk("R6", $sformatf("frozen at edge %0d", k), CW'(frozen), CW'(k >= 5 + D));
        end
        chk("R7", "held while frozen", cnt, CW'(D));
        chk("R5", "sticky after freeze", CW'(sticky), 48'd1);
        evt = '0;
    endtask

    task automatic t_unfreeze;
        frz_clr = 1'b1; ovf_clr = 1'b1;
        cyc(NE'(1) << 10);
        frz_clr = 1'b0; ovf_clr = 1'b0;
        chk("R9", "freeze lifted", CW'(frozen), '0);
        chk("R9", "no count on clear edge", cnt, CW'(D));
        for (int k = 0; k < 3; k++) cyc(NE'(1) << 10);
        evt = '0;
        chk("R9", "resumed from held value", cnt, CW'(D + 3));
    endtask

    task automatic t_pattern;
        logic [13:0] pat = 14'b11_0111_0110_0101;
        logic [CW-1:0] pre = ALL1 - 48'd2;
        logic [CW-1:0] mcnt;
        int ovf_k = -1;
        bit mfrz = 1'b0;
        cfg(9'h051, 1'b1, 1'b1);
        load(pre, '0);
        mcnt = pre;
        for (int k = 1; k <= 14; k++) begin
            cyc(NE'(pat[k-1]) << 6);
            if (pat[k-1] && !mfrz) begin
                if (mcnt == ALL1) ovf_k = k;
                mcnt = mcnt + 1'b1;
            end
            mfrz = (ovf_k > 0) && (k >= ovf_k + D);
        end
        evt = '0;
        chk("R6", "irregular events frozen value", cnt, mcnt);
        chk("R6", "irregular events frozen", CW'(frozen), CW'(mfrz));
        frz_clr = 1'b1; ovf_clr = 1'b1;
        cyc('0);
        frz_clr = 1'b0; ovf_clr = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_codes();
        t_unassigned();
        t_disabled();
        t_write_masked_ovf();
        t_freeze();
        t_unfreeze();
        t_pattern();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule